// File: doc/BRIEF.md
# Receive Character Queue with Trigger Level and Idle Timeout

This block is the receive-side byte store of a 16550-style serial port. A deserializer hands it one byte per `in_valid` pulse, with `in_break` marking a line-break condition. The block keeps the bytes either in a 16-entry first-in first-out queue or, when queueing is off, in a single holding byte. It also maintains the receive status flags: data-ready, overrun and break.

Software reaches the block through three strobes. The data-register read pops the oldest byte. The line-status read clears the sticky error flags. The FIFO-control write selects queue mode, a trigger level and a receive flush. In queue mode the block compares the fill level against the trigger level. It also raises a pending indication when stored data has sat untouched for four character times. The character time arrives as a one-cycle `char_tick` pulse from the baud logic.

All state is reset by a synchronous active-high `rst`. Every status output comes straight from a flop.

Top module: `rx_char_queue`

## Requirements
- R1: After reset the block is in single-byte mode with trigger code 00, and `fill_count`, `data_ready`, `overrun`, `break_seen`, `trig_hit` and `idle_pend` are all 0.
- R2: In queue mode, bytes leave in arrival order. `rd_data` shows the popped byte in the cycle after `rd_strobe`, and it holds that value until the next `rd_strobe`.
- R3: In queue mode with 16 bytes stored, an incoming byte is discarded, the stored bytes are kept and `overrun` is set. `fill_count` never exceeds 16.
- R4: In single-byte mode a received byte replaces the holding byte and sets `data_ready`. If `data_ready` was already set and no read happens in the same cycle, `overrun` is set. A read returns the holding byte and clears `data_ready` and `break_seen`. `fill_count` equals `data_ready`.
- R5: A byte with `in_break` high is stored as 0x00 and sets both `break_seen` and `data_ready`.
- R6: In queue mode, a read of an empty queue returns 0x00. A read that leaves the queue empty clears `data_ready` and `break_seen`. In queue mode `data_ready` equals (`fill_count` != 0).
- R7: Trigger code `cfg_trig` 00/01/10/11 selects a level of 1/4/8/14 bytes. `trig_hit` is 1 exactly when the block is in queue mode and `fill_count` is at least that level.
- R8: In queue mode, every receive and every read restarts the idle count and clears `idle_pend`. On the fourth `char_tick` with no restart in between, `idle_pend` is set if the queue holds data; otherwise it stays clear.
- R9: A control write with `cfg_rx_flush` high empties the queue and clears `data_ready`, `break_seen` and `idle_pend`. It leaves `overrun` unchanged. Any receive or pop in that same cycle is discarded.
- R10: A control write whose `cfg_fifo_en` differs from the current mode switches the mode and forces the same flush as R9.
- R11: `lsr_rd` clears `overrun` and `break_seen`. A set from a receive in the same cycle takes priority over the clear.
- R12: A read and a receive in the same cycle both take effect, with the read first. A full queue that is read and written in the same cycle accepts the new byte without overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Received byte strobe from the deserializer |
| in_data | input | 8 | Received byte |
| in_break | input | 1 | Received item is a line break (stored as 0x00) |
| rd_strobe | input | 1 | Data-register read strobe |
| rd_data | output | 8 | Byte returned by the last read, valid the cycle after `rd_strobe` |
| cfg_wr | input | 1 | FIFO-control write strobe |
| cfg_fifo_en | input | 1 | Queue mode select carried by the control write |
| cfg_rx_flush | input | 1 | Receive flush request carried by the control write |
| cfg_trig | input | 2 | Trigger level code carried by the control write |
| lsr_rd | input | 1 | Line-status read strobe |
| char_tick | input | 1 | One pulse per character period |
| fill_count | output | 5 | Stored byte count |
| data_ready | output | 1 | Data-ready flag |
| overrun | output | 1 | Overrun flag |
| break_seen | output | 1 | Break flag |
| trig_hit | output | 1 | Fill level at or above the trigger level |
| idle_pend | output | 1 | Character-timeout pending |

## Verification
Two functions meet in the same cycle here: the pop from a data read and the push from a receive. This matters most at the full and empty boundaries. At those boundaries the order of the two operations decides whether an overrun happens, and whether `data_ready` and the idle timer are cleared or restarted.

Directed sequences provoke both edges. One fills the queue to 16 and then reads and receives together. Another reads the last byte while a break arrives. A long random phase then mixes receives, reads, status reads, ticks and control writes freely. A behavioural queue model judges every cycle, applying the read first and then the receive.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // trigger code -> fill threshold in bytes
  function automatic int trig_level(input logic [1:0] code);
    case (code)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/rxq_ram.sv
module rxq_ram #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wen,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          ren,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // read-first single-clock memory with a registered read port
  always_ff @(posedge clk) begin
    if (wen) mem[waddr] <= wdata;
    if (ren) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxq_timeout.sv
module rxq_timeout #(
  parameter int TICKS = 4,
  localparam int TW   = $clog2(TICKS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic cancel,
  input  logic tick,
  input  logic has_data,
  output logic pending
);
  logic [TW-1:0] cnt_q;
  logic          armed_q;
  logic          pend_q;

  always_ff @(posedge clk) begin
    if (rst || cancel) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
    end else if (restart) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
      pend_q  <= 1'b0;
    end else if (tick && armed_q) begin
      if (cnt_q == TW'(TICKS - 1)) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
        pend_q  <= has_data;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign pending = pend_q;

  // R8: pending only rises when data was stored at expiry
  p_rise_needs_data_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> $past(has_data));
  // R8: a restart clears pending on the next cycle
  p_restart_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (restart && !cancel) |=> !pend_q);
  // R9: cancel clears pending
  p_cancel_clears_r9: assert property (@(posedge clk) disable iff (rst)
    cancel |=> !pend_q);
endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int TMO_TICKS = 4,
  localparam int AW       = $clog2(DEPTH),
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_break,
  input  logic          rd_strobe,
  output logic [7:0]    rd_data,
  input  logic          cfg_wr,
  input  logic          cfg_fifo_en,
  input  logic          cfg_rx_flush,
  input  logic [1:0]    cfg_trig,
  input  logic          lsr_rd,
  input  logic          char_tick,
  output logic [CW-1:0] fill_count,
  output logic          data_ready,
  output logic          overrun,
  output logic          break_seen,
  output logic          trig_hit,
  output logic          idle_pend
);
  // registered state
  logic          fifo_en_q;
  logic [1:0]    trig_code_q;
  logic [CW-1:0] count_q;
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic          dr_q, brk_q, ovr_q, trig_q;
  logic [CW-1:0] fill_q;
  logic [7:0]    hold_q;
  logic          rd_sel_q;
  logic [7:0]    rd_byte_q;
  logic [7:0]    ram_q;

  // next-state terms
  logic          flush, do_pop, do_push, room;
  logic          ovr_set, brk_set, dr_set, rd_clear;
  logic [7:0]    rx_byte;
  logic [CW-1:0] count_n, fill_n;
  logic          dr_n, brk_n, ovr_n, trig_n, fifo_en_n;
  logic [1:0]    trig_code_n;
  logic          tmo_restart;

  always_comb begin
    flush     = cfg_wr && (cfg_rx_flush || (cfg_fifo_en != fifo_en_q));
    rx_byte   = in_break ? 8'h00 : in_data;
    do_pop    = !flush && fifo_en_q && rd_strobe && (count_q != '0);
    room      = (count_q != CW'(DEPTH)) || do_pop;
    do_push   = !flush && fifo_en_q && in_valid && room;

    if (flush)                  count_n = '0;
    else if (do_push && !do_pop) count_n = count_q + 1'b1;
    else if (do_pop && !do_push) count_n = count_q - 1'b1;
    else                        count_n = count_q;

    ovr_set  = !flush && in_valid && (fifo_en_q ? !room : (dr_q && !rd_strobe));
    brk_set  = !flush && in_valid && in_break;
    dr_set   = !flush && in_valid;
    rd_clear = flush || (rd_strobe && (fifo_en_q ? (count_n == '0) : 1'b1));

    dr_n  = dr_set  | (dr_q  & ~rd_clear);
    brk_n = brk_set | (brk_q & ~rd_clear & ~lsr_rd);
    ovr_n = ovr_set | (ovr_q & ~lsr_rd);

    fifo_en_n   = cfg_wr ? cfg_fifo_en : fifo_en_q;
    trig_code_n = cfg_wr ? cfg_trig    : trig_code_q;
    fill_n      = fifo_en_n ? count_n : CW'(dr_n);
    trig_n      = fifo_en_n && (int'(count_n) >= trig_level(trig_code_n));

    tmo_restart = !flush && fifo_en_q && (rd_strobe || in_valid);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_en_q   <= 1'b0;
      trig_code_q <= 2'b00;
      count_q     <= '0;
      wr_ptr_q    <= '0;
      rd_ptr_q    <= '0;
      dr_q        <= 1'b0;
      brk_q       <= 1'b0;
      ovr_q       <= 1'b0;
      trig_q      <= 1'b0;
      fill_q      <= '0;
      hold_q      <= 8'h00;
      rd_sel_q    <= 1'b0;
      rd_byte_q   <= 8'h00;
    end else begin
      fifo_en_q   <= fifo_en_n;
      trig_code_q <= trig_code_n;
      count_q     <= count_n;
      dr_q        <= dr_n;
      brk_q       <= brk_n;
      ovr_q       <= ovr_n;
      trig_q      <= trig_n;
      fill_q      <= fill_n;
      if (flush) begin
        wr_ptr_q <= '0;
        rd_ptr_q <= '0;
      end else begin
        if (do_push) wr_ptr_q <= (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
        if (do_pop)  rd_ptr_q <= (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      end
      if (!flush && !fifo_en_q && in_valid) hold_q <= rx_byte;
      if (rd_strobe) begin
        rd_sel_q  <= fifo_en_q && (count_q != '0);
        rd_byte_q <= fifo_en_q ? 8'h00 : hold_q;
      end
    end
  end

  rxq_ram #(.DEPTH(DEPTH), .W(8)) u_ram (
    .clk   (clk),
    .wen   (do_push),
    .waddr (wr_ptr_q),
    .wdata (rx_byte),
    .ren   (rd_strobe),
    .raddr (rd_ptr_q),
    .rdata (ram_q)
  );

  rxq_timeout #(.TICKS(TMO_TICKS)) u_tmo (
    .clk      (clk),
    .rst      (rst),
    .restart  (tmo_restart),
    .cancel   (flush),
    .tick     (char_tick),
    .has_data (count_q != '0),
    .pending  (idle_pend)
  );

  assign rd_data    = rd_sel_q ? ram_q : rd_byte_q;
  assign fill_count = fill_q;
  assign data_ready = dr_q;
  assign overrun    = ovr_q;
  assign break_seen = brk_q;
  assign trig_hit   = trig_q;

  // R3: stored count bounded by depth
  p_fill_bound_r3: assert property (@(posedge clk) disable iff (rst)
    count_q <= CW'(DEPTH));
  // R3: full, written, not read -> dropped and overrun flagged
  p_full_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (fifo_en_q && count_q == CW'(DEPTH) && in_valid && !rd_strobe && !cfg_wr)
      |=> (ovr_q && count_q == CW'(DEPTH)));
  // R4: queue unused in single-byte mode
  p_single_slot_r4: assert property (@(posedge clk) disable iff (rst)
    !fifo_en_q |-> count_q == '0);
  // R6: data-ready follows occupancy in queue mode
  p_dr_tracks_fill_r6: assert property (@(posedge clk) disable iff (rst)
    fifo_en_q |-> (dr_q == (count_q != '0)));
  // R7: trigger only with stored data in queue mode
  p_trig_needs_data_r7: assert property (@(posedge clk) disable iff (rst)
    trig_q |-> (fifo_en_q && count_q != '0));
  // R9: explicit flush empties the queue
  p_flush_empties_r9: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_rx_flush) |=> (count_q == '0 && !dr_q && !brk_q));
  // R11: status read without a receive clears sticky flags
  p_lsr_clears_r11: assert property (@(posedge clk) disable iff (rst)
    (lsr_rd && !in_valid) |=> (!ovr_q && !brk_q));
endmodule

// File: tb/tb_rx_char_queue.sv
module tb_rx_char_queue;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 0, in_break = 0, rd_strobe = 0, cfg_wr = 0;
  logic cfg_fifo_en = 0, cfg_rx_flush = 0, lsr_rd = 0, char_tick = 0;
  logic [7:0] in_data = 0;
  logic [1:0] cfg_trig = 0;
  logic [7:0] rd_data;
  logic [4:0] fill_count;
  logic data_ready, overrun, break_seen, trig_hit, idle_pend;

  always #5 clk = ~clk;

  rx_char_queue dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_break(in_break), .rd_strobe(rd_strobe), .rd_data(rd_data),
    .cfg_wr(cfg_wr), .cfg_fifo_en(cfg_fifo_en), .cfg_rx_flush(cfg_rx_flush),
    .cfg_trig(cfg_trig), .lsr_rd(lsr_rd), .char_tick(char_tick),
    .fill_count(fill_count), .data_ready(data_ready), .overrun(overrun),
    .break_seen(break_seen), .trig_hit(trig_hit), .idle_pend(idle_pend)
  );

  // ---------------- reference model ----------------
  logic [7:0] q[$];
  bit m_en, m_dr, m_brk, m_ovr, m_armed, m_pend;
  logic [1:0] m_code;
  int m_cnt;
  logic [7:0] m_hold, exp_rd, b;
  bit exp_rd_pend, started;
  bit fl, rdclr, dset, bset, oset;

  function automatic int lvl(input logic [1:0] c);
    int t[4] = '{1, 4, 8, 14};
    return t[c];
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      q.delete(); m_en = 0; m_dr = 0; m_brk = 0; m_ovr = 0; m_armed = 0;
      m_pend = 0; m_code = 0; m_cnt = 0; m_hold = 0; exp_rd_pend = 0;
    end else begin
      fl = cfg_wr && (cfg_rx_flush || (cfg_fifo_en != m_en));
      rdclr = 0; dset = 0; bset = 0; oset = 0;
      b = in_break ? 8'h00 : in_data;
      if (rd_strobe) begin
        exp_rd = m_en ? ((q.size() > 0) ? q[0] : 8'h00) : m_hold;
        exp_rd_pend = 1;
      end
      if (fl) begin
        q.delete(); m_dr = 0; m_brk = 0; m_armed = 0; m_pend = 0; m_cnt = 0;
      end else if (m_en) begin
        if (rd_strobe && q.size() > 0) void'(q.pop_front());
        if (in_valid) begin
          if (q.size() < DEPTH) q.push_back(b); else oset = 1;
          dset = 1; bset = in_break;
        end
        rdclr = rd_strobe && (q.size() == 0);
        if (rd_strobe || in_valid) begin
          m_cnt = 0; m_armed = 1; m_pend = 0;
        end else if (char_tick && m_armed) begin
          m_cnt++;
          if (m_cnt == 4) begin m_cnt = 0; m_armed = 0; m_pend = (q.size() > 0); end
        end
      end else begin
        rdclr = rd_strobe;
        if (in_valid) begin
          oset = m_dr && !rd_strobe; m_hold = b; dset = 1; bset = in_break;
        end
      end
      m_dr  = dset | (m_dr & !rdclr);
      m_brk = bset | (m_brk & !rdclr & !lsr_rd);
      m_ovr = oset | (m_ovr & !lsr_rd);
      if (cfg_wr) begin m_en = cfg_fifo_en; m_code = cfg_trig; end
    end
  end

  // ---------------- comparison ----------------
  int n_cmp = 0, n_bad = 0;
  string phase = "R1 reset";
  bit done = 0;

  task automatic chk(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("fill_count R3", int'(fill_count), m_en ? q.size() : int'(m_dr));
      chk("data_ready R6", int'(data_ready), int'(m_dr));
      chk("overrun R11",   int'(overrun),    int'(m_ovr));
      chk("break_seen R5", int'(break_seen), int'(m_brk));
      chk("trig_hit R7",   int'(trig_hit),   int'(m_en && (q.size() >= lvl(m_code))));
      chk("idle_pend R8",  int'(idle_pend),  int'(m_pend));
      if (exp_rd_pend) begin
        chk("rd_data R2", int'(rd_data), int'(exp_rd));
        exp_rd_pend = 0;
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input bit v, input logic [7:0] d, input bit bk, input bit rd,
                      input bit ls, input bit tk, input bit cw, input bit ce,
                      input bit cf, input logic [1:0] ct);
    @(negedge clk);
    in_valid = v; in_data = d; in_break = bk; rd_strobe = rd; lsr_rd = ls;
    char_tick = tk; cfg_wr = cw; cfg_fifo_en = ce; cfg_rx_flush = cf; cfg_trig = ct;
  endtask
  task automatic idle(); step(0,0,0,0,0,0,0,0,0,0); endtask
  task automatic rx(input logic [7:0] d); step(1,d,0,0,0,0,0,0,0,0); endtask
  task automatic rd(); step(0,0,0,1,0,0,0,0,0,0); endtask
  task automatic tk(); step(0,0,0,0,0,1,0,0,0,0); endtask
  task automatic cfg(input bit ce, input bit cf, input logic [1:0] ct);
    step(0,0,0,0,0,0,1,ce,cf,ct);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    idle(); idle();
    // single-byte mode
    phase = "R4 single";
    rx(8'h41); idle(); rd(); idle(); rx(8'h42); rx(8'h43); idle(); rd(); idle();
    step(0,0,0,0,1,0,0,0,0,0); idle();
    rx(8'h44); step(1,8'h45,0,1,0,0,0,0,0,0); idle(); rd(); idle();
    // mode switch forces flush
    phase = "R10 mode";
    rx(8'h46); cfg(1,0,2'b01); idle();
    phase = "R7 trig";
    for (int i = 0; i < 5; i++) begin rx(8'h10 + 8'(i)); idle(); end
    phase = "R2 order";
    for (int i = 0; i < 5; i++) begin rd(); idle(); end
    phase = "R6 empty";
    rd(); idle(); rd(); idle();
    phase = "R3 full";
    for (int i = 0; i < 18; i++) rx(8'h80 + 8'(i));
    idle();
    phase = "R11 lsr";
    step(0,0,0,0,1,0,0,0,0,0); idle();
    step(1,8'h99,0,0,1,0,0,0,0,0); idle();
    phase = "R12 same";
    step(1,8'hA5,0,1,0,0,0,0,0,0); idle();
    for (int i = 0; i < 15; i++) rd();
    step(1,8'h00,1,1,0,0,0,0,0,0); idle();
    phase = "R5 break";
    rd(); idle(); step(1,8'h77,1,0,0,0,0,0,0,0); idle();
    phase = "R8 timeout";
    for (int i = 0; i < 5; i++) tk();
    rx(8'h31); tk(); tk(); rd(); for (int i = 0; i < 5; i++) tk();
    rx(8'h32); for (int i = 0; i < 4; i++) tk(); idle();
    phase = "R9 flush";
    step(1,8'h55,0,1,0,0,1,1,1,2'b10); idle(); rd(); idle();
    phase = "R7 levels";
    cfg(1,0,2'b11);
    for (int i = 0; i < 15; i++) rx(8'(i));
    cfg(1,0,2'b10); cfg(1,1,2'b00); idle();
    phase = "R12 random";
    for (int i = 0; i < 6000; i++) begin
      int r = $urandom_range(0, 99);
      bit cwr = (r < 2);
      step($urandom_range(0,99) < 45, 8'($urandom), $urandom_range(0,99) < 5,
           $urandom_range(0,99) < 35, $urandom_range(0,99) < 10,
           $urandom_range(0,99) < 25, cwr, $urandom_range(0,99) < 85,
           $urandom_range(0,99) < 30, 2'($urandom));
    end
    idle(); idle(); idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog %s: actual=%0d expected=%0d", phase, cycles, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule